// File: doc/BRIEF.md
# Address Window Chip-Select Decoder

This block sits in front of an external bus controller. For each external access it takes the 24-bit access address and finds which of four programmable address windows the address falls in. If the address is in none of them, the access falls to a default region. The result is the index of the bus-configuration set that governs the access, plus one active-low chip-select line per window and one for the default region.

Each window is described by a base address, a power-of-two size code and an enable bit. Overlapping windows are resolved by a fixed priority in which the higher-numbered window wins.

The external address space can be narrowed to fewer upper segment lines. The lines that are not driven are treated as zero, both on the segment outputs and by the decoder. The chip selects can be registered once per access, or driven straight from the address. A small counter records the wait states that a ready input inserts while the ready function is enabled.

Top module: `csd_top`

## Requirements
- R1: Window k (k = 1..4) uses base `win_base[24k-1:24(k-1)]`, size code `win_size[4k-1:4(k-1)]` and enable `win_en[k-1]`. Its size is 2^(12+code) bytes, and the base bits below the size are ignored. A window hits when it is enabled and the effective address matches the base on every bit at or above the size. A code of 12 or more covers the whole space.
- R2: An access that hits no enabled window selects configuration index 0 and drives `cs_n[0]` low.
- R3: When windows overlap, the highest-numbered hitting window wins: 4, then 3, then 2, then 1, then the default.
- R4: At most one `cs_n` bit is low at any time. `cs_n[k]` belongs to window k and `cs_n[0]` to the default region. `cfg_sel` carries the winning index (0 for default) while `acc_valid` is high.
- R5: With `cs_unlatched` = 1, `cs_n` follows `acc_valid` and the address combinationally, in the same cycle.
- R6: With `cs_unlatched` = 0, `cs_n` is registered. It takes the decode of the address present at the first cycle of an access and shows it from the next cycle on. It holds that value through inserted wait states, even if the address changes.
- R7: While `acc_valid` is low, `cfg_sel` is 0. All `cs_n` bits are high at once in unlatched mode, and from the next clock edge in latched mode.
- R8: `space_sel` picks the space size and the number of driven segment lines `seg_addr`: 00 gives 16 MB and 8 lines, 01 gives 1 MB and 4 lines, 10 gives 256 KB and 2 lines, 11 gives 64 KB and 0 lines. `seg_addr[i]` is address bit 16+i for the driven lines and 0 above them.
- R9: Window decode uses the effective address: the driven segment lines with the low 16 address bits below them, and zero for the undriven upper bits.
- R10: `wait_req` is high exactly when `acc_valid`, `rdy_en` and `rdy_in` are all high. With `rdy_en` low, `rdy_in` has no effect.
- R11: An access continues after a cycle with `wait_req` high; any other valid cycle starts a new access. `wait_cnt` counts the wait cycles of the current access, including the first cycle. It is cleared at a start without a wait and while idle, and it saturates at 15.
- R12: During reset all `cs_n` bits are high and `wait_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | External access in progress |
| acc_addr | input | 24 | Access address |
| win_base | input | 96 | Window base addresses, window k in slice k-1 |
| win_size | input | 16 | Window size codes, 4 bits each |
| win_en | input | 4 | Window enables |
| cs_unlatched | input | 1 | 1: combinational chip selects, 0: registered |
| space_sel | input | 2 | Address space size selector |
| rdy_en | input | 1 | Ready function enable |
| rdy_in | input | 1 | Ready input, high inserts a wait state |
| cfg_sel | output | 3 | Selected configuration index |
| cs_n | output | 5 | Active-low chip selects |
| seg_addr | output | 8 | Upper segment address lines |
| wait_req | output | 1 | Wait state requested this cycle |
| wait_cnt | output | 4 | Wait states inserted in current access |

## Verification
The assertions check the following on every cycle:
- at most one chip select is active;
- in unlatched mode the active line agrees with the selected index;
- chip selects go inactive when the bus is idle;
- a latched chip select stays unchanged within an access;
- no wait request is raised without an access, and the wait counter steps by one;
- no segment line is driven in the smallest space.

Only the directed scenarios can show that the decoded window is correct for a given base, size and overlap pattern. The same holds for how the space restriction folds high addresses into low windows, and for the counter saturating after a long run of waits.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [1:0] {
    SPC_16M  = 2'b00,
    SPC_1M   = 2'b01,
    SPC_256K = 2'b10,
    SPC_64K  = 2'b11
  } space_e;

  // number of driven upper segment lines for a space selection
  function automatic int unsigned seg_lines(input space_e sel);
    case (sel)
      SPC_16M:  return 8;
      SPC_1M:   return 4;
      SPC_256K: return 2;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/csd_win_match.sv
module csd_win_match #(
  parameter int ADDR_W    = 24,
  parameter int SIZE_W    = 4,
  parameter int MIN_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              en,
  output logic              hit
);

  // bits at or above the window size take part in the compare
  function automatic logic [ADDR_W-1:0] cmp_mask(input logic [SIZE_W-1:0] code);
    logic [ADDR_W-1:0] m;
    int unsigned sh;
    sh = MIN_SHIFT + int'(code);
    for (int i = 0; i < ADDR_W; i++) m[i] = (i >= sh);
    return m;
  endfunction

  logic [ADDR_W-1:0] mask;
  assign mask = cmp_mask(size_code);
  assign hit  = en && (((addr ^ base) & mask) == '0);

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic [IDX_W-1:0]   idx
);

  // ascending scan: a later (higher-numbered) hit overrides an earlier one
  always_comb begin
    idx = '0;
    for (int k = 1; k <= NUM_WIN; k++) begin
      if (hits[k-1]) idx = IDX_W'(k);
    end
  end

endmodule

// File: rtl/csd_wait.sv
module csd_wait #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              rdy_en,
  input  logic              rdy_in,
  output logic              wait_req,
  output logic              acc_start,
  output logic [WAIT_W-1:0] wait_cnt
);

  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

  logic in_wait_q;

  function automatic logic [WAIT_W-1:0] sat_inc(input logic [WAIT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + WAIT_W'(1);
  endfunction

  assign wait_req  = acc_valid && rdy_en && rdy_in;
  assign acc_start = acc_valid && !in_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wait_q <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      in_wait_q <= wait_req;
      if (!acc_valid)
        wait_cnt <= '0;
      else if (acc_start)
        wait_cnt <= wait_req ? WAIT_W'(1) : '0;
      else if (wait_req)
        wait_cnt <= sat_inc(wait_cnt);
    end
  end

endmodule

// File: rtl/csd_top.sv
module csd_top #(
  parameter int ADDR_W    = 24,
  parameter int NUM_WIN   = 4,
  parameter int SIZE_W    = 4,
  parameter int MIN_SHIFT = 12,
  parameter int LOW_W     = 16,
  parameter int WAIT_W    = 4,
  localparam int IDX_W    = $clog2(NUM_WIN + 1),
  localparam int CS_W     = NUM_WIN + 1,
  localparam int SEG_W    = ADDR_W - LOW_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [NUM_WIN*ADDR_W-1:0] win_base,
  input  logic [NUM_WIN*SIZE_W-1:0] win_size,
  input  logic [NUM_WIN-1:0]        win_en,
  input  logic                      cs_unlatched,
  input  logic [1:0]                space_sel,
  input  logic                      rdy_en,
  input  logic                      rdy_in,
  output logic [IDX_W-1:0]          cfg_sel,
  output logic [CS_W-1:0]           cs_n,
  output logic [SEG_W-1:0]          seg_addr,
  output logic                      wait_req,
  output logic [WAIT_W-1:0]         wait_cnt
);

  import csd_pkg::*;

  function automatic logic [SEG_W-1:0] seg_mask(input logic [1:0] sel);
    logic [SEG_W-1:0] m;
    int unsigned n;
    n = seg_lines(space_e'(sel));
    for (int i = 0; i < SEG_W; i++) m[i] = (i < n);
    return m;
  endfunction

  logic [ADDR_W-1:0]  eff_addr;
  logic [NUM_WIN-1:0] win_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [CS_W-1:0]    cs_act;
  logic [CS_W-1:0]    cs_comb_n;
  logic [CS_W-1:0]    cs_q;
  logic               acc_start;

  assign seg_addr = acc_addr[ADDR_W-1:LOW_W] & seg_mask(space_sel);
  assign eff_addr = {seg_addr, acc_addr[LOW_W-1:0]};

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    csd_win_match #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_SHIFT(MIN_SHIFT)
    ) u_match (
      .addr      (eff_addr),
      .base      (win_base[k*ADDR_W +: ADDR_W]),
      .size_code (win_size[k*SIZE_W +: SIZE_W]),
      .en        (win_en[k]),
      .hit       (win_hit[k])
    );
  end

  csd_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .hits (win_hit),
    .idx  (win_idx)
  );

  csd_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .rdy_en    (rdy_en),
    .rdy_in    (rdy_in),
    .wait_req  (wait_req),
    .acc_start (acc_start),
    .wait_cnt  (wait_cnt)
  );

  assign cs_act    = CS_W'(1) << win_idx;
  assign cs_comb_n = acc_valid ? ~cs_act : '1;
  assign cfg_sel   = acc_valid ? win_idx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cs_q <= '1;
    else if (!acc_valid) cs_q <= '1;
    else if (acc_start)  cs_q <= ~cs_act;
  end

  assign cs_n = cs_unlatched ? cs_comb_n : cs_q;

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int IDX_W  = 3,
  parameter int CS_W   = 5,
  parameter int SEG_W  = 8,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              cs_unlatched,
  input logic [1:0]        space_sel,
  input logic [IDX_W-1:0]  cfg_sel,
  input logic [CS_W-1:0]   cs_n,
  input logic [SEG_W-1:0]  seg_addr,
  input logic              wait_req,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic              acc_start
);

  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r4_cfg_matches_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cs_unlatched) |-> (cs_n[cfg_sel] == 1'b0));

  a_r7_idle_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && cs_unlatched) |-> (cs_n == '1 && cfg_sel == '0));

  a_r7_idle_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (cs_unlatched || cs_n == '1));

  a_r6_hold_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_unlatched && acc_valid && !acc_start) |=> (cs_unlatched || $stable(cs_n)));

  a_r8_no_seg_small: assert property (@(posedge clk) disable iff (!rst_n)
    (space_sel == 2'b11) |-> (seg_addr == '0));

  a_r10_no_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !wait_req);

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_start && wait_req && wait_cnt != '1)
      |=> (wait_cnt == $past(wait_cnt) + WAIT_W'(1)));

  a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (wait_cnt == '0));

endmodule

bind csd_top csd_checker #(
  .IDX_W(IDX_W), .CS_W(CS_W), .SEG_W(SEG_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .cs_unlatched (cs_unlatched),
  .space_sel    (space_sel),
  .cfg_sel      (cfg_sel),
  .cs_n         (cs_n),
  .seg_addr     (seg_addr),
  .wait_req     (wait_req),
  .wait_cnt     (wait_cnt),
  .acc_start    (acc_start)
);

// File: tb/sim_csd_top.sv
`timescale 1ns/1ps
module sim_csd_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [95:0] win_base;
  logic [15:0] win_size;
  logic [3:0]  win_en;
  logic        cs_unlatched = 1'b0;
  logic [1:0]  space_sel = 2'b00;
  logic        rdy_en = 1'b0;
  logic        rdy_in = 1'b0;
  logic [2:0]  cfg_sel;
  logic [4:0]  cs_n;
  logic [7:0]  seg_addr;
  logic        wait_req;
  logic [3:0]  wait_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [23:0] bases [1:4];
  int          codes [1:4];
  bit          ens   [1:4];

  always #2.5 clk = ~clk;

  csd_top u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .win_base(win_base), .win_size(win_size), .win_en(win_en),
    .cs_unlatched(cs_unlatched), .space_sel(space_sel),
    .rdy_en(rdy_en), .rdy_in(rdy_in), .cfg_sel(cfg_sel), .cs_n(cs_n),
    .seg_addr(seg_addr), .wait_req(wait_req), .wait_cnt(wait_cnt)
  );

  always_comb begin
    for (int k = 1; k <= 4; k++) begin
      win_base[(k-1)*24 +: 24] = bases[k];
      win_size[(k-1)*4 +: 4]   = 4'(codes[k]);
      win_en[k-1]              = ens[k];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int space_bytes(input logic [1:0] sel);
    case (sel)
      2'b00: return 1 << 24;
      2'b01: return 1 << 20;
      2'b10: return 1 << 18;
      default: return 1 << 16;
    endcase
  endfunction

  // range-based model: scan from window 4 down
  function automatic int ref_idx(input int addr, input logic [1:0] sel);
    int eff = addr % space_bytes(sel);
    for (int k = 4; k >= 1; k--) begin
      if (ens[k]) begin
        if (12 + codes[k] >= 24) return k;
        if (eff >= int'(bases[k]) && eff < int'(bases[k]) + (1 << (12 + codes[k])))
          return k;
      end
    end
    return 0;
  endfunction

  function automatic int cs_of(input int idx);
    return (~(1 << idx)) & 5'h1F;
  endfunction

  task automatic drive(input bit v, input int a);
    @(negedge clk);
    acc_valid = v;
    acc_addr  = 24'(a);
    #1;
  endtask

  task automatic setup_windows();
    bases[1] = 24'h010000; codes[1] = 4;  ens[1] = 1;
    bases[2] = 24'h018000; codes[2] = 3;  ens[2] = 1;
    bases[3] = 24'h400000; codes[3] = 10; ens[3] = 1;
    bases[4] = 24'h500000; codes[4] = 8;  ens[4] = 1;
  endtask

  task automatic t_reset();
    #1;
    chk("R12 cs_n in reset", int'(cs_n), 32'h1F);
    chk("R12 wait_cnt in reset", int'(wait_cnt), 0);
  endtask

  task automatic t_unlatched();
    int addrs [6] = '{32'h010004, 32'h01FFFF, 32'h000100, 32'h7FFFF0, 32'h5A0000, 32'hC00000};
    cs_unlatched = 1'b1;
    space_sel = 2'b00;
    foreach (addrs[i]) begin
      drive(1'b1, addrs[i]);
      chk("R1/R2 cfg_sel", int'(cfg_sel), ref_idx(addrs[i], 2'b00));
      chk("R4/R5 cs_n same cycle", int'(cs_n), cs_of(ref_idx(addrs[i], 2'b00)));
    end
    drive(1'b1, 32'h000010);
    chk("R2 default cs", int'(cs_n), 32'h1E);
    chk("R2 default cfg", int'(cfg_sel), 0);
  endtask

  task automatic t_priority();
    cs_unlatched = 1'b1;
    drive(1'b1, 32'h018000);
    chk("R3 w2 over w1", int'(cfg_sel), 2);
    drive(1'b1, 32'h520000);
    chk("R3 w4 over w3", int'(cfg_sel), 4);
    drive(1'b1, 32'h400000);
    chk("R3 w3 alone", int'(cfg_sel), 3);
    codes[3] = 12; bases[3] = 24'h000000;
    drive(1'b1, 32'h018000);
    chk("R3 w3 over w2", int'(cfg_sel), 3);
    drive(1'b1, 32'hF00000);
    chk("R1 whole-space window", int'(cs_n), 32'h17);
    drive(1'b1, 32'h500000);
    chk("R3 w4 over w3 whole", int'(cfg_sel), 4);
    setup_windows();
    ens[2] = 0;
    drive(1'b1, 32'h018000);
    chk("R1 disabled window", int'(cfg_sel), 1);
    ens[2] = 1;
  endtask

  task automatic t_space();
    cs_unlatched = 1'b1;
    for (int s = 0; s < 4; s++) begin
      space_sel = 2'(s);
      drive(1'b1, 32'h518000);
      chk("R8 seg_addr", int'(seg_addr), (32'h518000 % space_bytes(2'(s))) >> 16);
      chk("R9 effective decode", int'(cfg_sel), ref_idx(32'h518000, 2'(s)));
    end
    space_sel = 2'b00;
  endtask

  task automatic t_idle();
    cs_unlatched = 1'b1;
    drive(1'b0, 32'h018000);
    chk("R7 idle cs_n unlatched", int'(cs_n), 32'h1F);
    chk("R7 idle cfg_sel", int'(cfg_sel), 0);
  endtask

  task automatic t_latched();
    cs_unlatched = 1'b0;
    rdy_en = 1'b1;
    drive(1'b0, 0);
    @(posedge clk); #1;
    chk("R7 latched idle", int'(cs_n), 32'h1F);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 24'h500010; rdy_in = 1'b1;
    #1;
    chk("R6 not before edge", int'(cs_n), 32'h1F);
    @(posedge clk); #1;
    chk("R6 latched w4", int'(cs_n), 32'h0F);
    chk("R11 first wait", int'(wait_cnt), 1);
    @(negedge clk); acc_addr = 24'h010000;
    @(posedge clk); #1;
    chk("R6 held in wait", int'(cs_n), 32'h0F);
    chk("R11 second wait", int'(wait_cnt), 2);
    @(negedge clk); rdy_in = 1'b0;
    @(posedge clk); #1;
    chk("R6 held last cycle", int'(cs_n), 32'h0F);
    chk("R11 count kept", int'(wait_cnt), 2);
    @(posedge clk); #1;
    chk("R6 new access w1", int'(cs_n), 32'h1D);
    chk("R11 cleared at start", int'(wait_cnt), 0);
    @(negedge clk); acc_valid = 1'b0;
    #1;
    chk("R7 latched still held", int'(cs_n), 32'h1D);
    @(posedge clk); #1;
    chk("R7 latched idle after edge", int'(cs_n), 32'h1F);
  endtask

  task automatic t_ready();
    cs_unlatched = 1'b1;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 24'h010000; rdy_en = 1'b0; rdy_in = 1'b1;
    #1;
    chk("R10 no wait when disabled", int'(wait_req), 0);
    @(posedge clk); #1;
    chk("R10 count untouched", int'(wait_cnt), 0);
    @(negedge clk); rdy_en = 1'b1;
    #1;
    chk("R10 wait when enabled", int'(wait_req), 1);
    repeat (20) @(posedge clk);
    #1;
    chk("R11 saturation", int'(wait_cnt), 15);
    @(negedge clk); acc_valid = 1'b0; rdy_in = 1'b0;
    #1;
    chk("R10 no wait idle", int'(wait_req), 0);
    @(posedge clk); #1;
    chk("R11 cleared idle", int'(wait_cnt), 0);
  endtask

  initial begin
    setup_windows();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_unlatched();
    t_priority();
    t_space();
    t_idle();
    t_latched();
    t_ready();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule